// File: doc/BRIEF.md
# One-Shot Strobe Down-Counter

This block is a single counter channel that pulls its active-low output low for exactly one clock when a programmed count runs out. A control word picks how a sequence starts and whether the count is binary or four-digit BCD. The count is then written one byte at a time, low byte first. In software-start mode, completing a count write starts the sequence, and writing a new count restarts it. In gate-start mode, a low-to-high transition on the gate input starts the sequence, and every further transition restarts it from the stored count.

A sequence always spends one clock loading the counter without decrementing it. A count of N therefore gives the strobe N+1 clocks after the start. A count of zero stands for the full range of the count format. After expiry the counter wraps and keeps running silently until it is loaded again. Every register uses the rising edge of one clock and a synchronous active-high reset.

Top module: `strobe_counter`

## Requirements
- R1: After reset, strobe_n is high and no strobe appears until a count has been loaded.
- R2: A control write (ctrl_mode 0 = software start, 1 = gate start; ctrl_bcd 1 = BCD, 0 = binary) makes strobe_n high from the next cycle on. It abandons any running sequence and returns the byte order to the low byte. A count byte offered in the same cycle as the control write is discarded.
- R3: Each strobe lasts exactly one clock cycle low and is followed by a high cycle.
- R4: In software-start mode, when the high count byte is sampled at clock edge k, the counter loads at edge k+1 without decrementing. strobe_n is low in the cycle after edge k+N+1.
- R5: In software-start mode, each edge at which gate is sampled low skips one decrement, which delays the strobe by one cycle. Gate never drives strobe_n directly.
- R6: A count is written low byte first, then high byte. The low byte alone has no effect on a running sequence. The high byte written mid-sequence in software-start mode reloads the counter, and the earlier strobe never appears.
- R7: In gate-start mode, a trigger is captured at an edge where gate is sampled high after being sampled low at the previous edge. The counter loads at the next edge and strobe_n goes low N+1 cycles after the capture edge. Gate level does not pause counting, and triggers are ignored until a full count has been written after the control write.
- R8: In gate-start mode, a trigger during a running sequence reloads the stored count and restarts the timing, and the earlier strobe never appears.
- R9: In gate-start mode, a count written during a running sequence leaves that sequence's timing unchanged and is used by the next trigger.
- R10: A count of 0 means 65536 decrements in binary and 10000 in BCD.
- R11: After expiry the counter wraps to all-ones (binary) or 9999 (BCD) and keeps counting without another strobe until it is reloaded.
- R12: In BCD mode every 4-bit digit stays in 0..9, with a borrow rippling into the next digit, provided the written count is valid BCD.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_mode | input | 1 | Start mode: 0 software start, 1 gate start |
| ctrl_bcd | input | 1 | Count format: 1 BCD, 0 binary |
| cnt_we | input | 1 | Count byte write strobe |
| cnt_byte | input | 8 | Count byte, low byte first |
| gate | input | 1 | Count enable (software start) or trigger (gate start) |
| strobe_n | output | 1 | Active-low one-cycle expiry strobe |

## Verification
The assertions assume that gate and the write strobes are synchronous to clk and that each gate trigger holds for at least one sampled edge. The digit-range check also relies on every count written in BCD mode being valid BCD. The stimulus drives all inputs on the falling edge, holds each gate pulse high for a full cycle, and writes only valid BCD counts while BCD is selected. This keeps every input inside those assumptions while still reaching mid-sequence reloads, retriggers, gate pauses and full-range wrap.

// File: rtl/strobe_pkg.sv
package strobe_pkg;
  typedef enum logic {
    TRIG_SOFT = 1'b0,
    TRIG_HARD = 1'b1
  } trig_mode_e;

  localparam int unsigned NIBBLE_W = 4;
  localparam int unsigned BYTE_W   = 8;
endpackage

// File: rtl/strobe_dec_unit.sv
// Digit-wise decrement: binary and BCD share one borrow chain, only the
// value a digit takes when it underflows differs.
module strobe_dec_unit
  import strobe_pkg::*;
#(
  parameter int unsigned DIGITS = 4
) (
  input  logic [DIGITS*NIBBLE_W-1:0] cur,
  input  logic                       bcd,
  output logic [DIGITS*NIBBLE_W-1:0] nxt
);
  always_comb begin
    logic                borrow;
    logic [NIBBLE_W-1:0] d;
    borrow = 1'b1;
    nxt    = cur;
    for (int i = 0; i < int'(DIGITS); i++) begin
      d = cur[i*NIBBLE_W +: NIBBLE_W];
      if (borrow) begin
        if (d == '0) begin
          nxt[i*NIBBLE_W +: NIBBLE_W] = bcd ? 4'd9 : 4'hF;
        end else begin
          nxt[i*NIBBLE_W +: NIBBLE_W] = d - 4'd1;
          borrow = 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/strobe_gate_edge.sv
// Captures a low-to-high gate transition into a one-cycle trigger flag that
// the counter consumes on the following edge.
module strobe_gate_edge (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic arm,
  input  logic gate,
  output logic trig
);
  logic gate_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q <= 1'b0;
      trig   <= 1'b0;
    end else begin
      gate_q <= gate;
      trig   <= arm & ~clr & gate & ~gate_q;
    end
  end

  // R7: the capture flag is cleared right after it is sampled
  p_capture_clears_r7: assert property (@(posedge clk) disable iff (rst)
    trig |=> !trig);
endmodule

// File: rtl/strobe_count_stage.sv
// Assembles the count from byte writes, low byte first; a commit pulse marks
// the cycle after the final byte arrives.
module strobe_count_stage
  import strobe_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              we,
  input  logic [BYTE_W-1:0] byte_in,
  output logic [CNT_W-1:0]  value,
  output logic              commit,
  output logic              have
);
  localparam int unsigned BYTES = CNT_W / BYTE_W;
  localparam int unsigned IDX_W = (BYTES > 1) ? $clog2(BYTES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BYTES - 1);

  logic [IDX_W-1:0] idx_q;
  logic [CNT_W-1:0] stage_q;
  logic [CNT_W-1:0] merged;
  logic             last;

  always_comb begin
    merged = stage_q;
    merged[idx_q*BYTE_W +: BYTE_W] = byte_in;
  end

  assign last = (idx_q == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      idx_q   <= '0;
      stage_q <= '0;
      commit  <= 1'b0;
      have    <= 1'b0;
      if (rst) value <= '0;
    end else begin
      commit <= 1'b0;
      if (we) begin
        stage_q <= merged;
        if (last) begin
          idx_q  <= '0;
          value  <= merged;
          commit <= 1'b1;
          have   <= 1'b1;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  // R6: a byte that does not complete the count never requests a load
  p_partial_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (we && !last && !clr) |=> !commit);
endmodule

// File: rtl/strobe_counter.sv
module strobe_counter
  import strobe_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_we,
  input  logic              ctrl_mode,
  input  logic              ctrl_bcd,
  input  logic              cnt_we,
  input  logic [BYTE_W-1:0] cnt_byte,
  input  logic              gate,
  output logic              strobe_n
);
  localparam int unsigned DIGITS = CNT_W / NIBBLE_W;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  trig_mode_e       mode_q;
  logic             bcd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             running_q;
  logic             armed_q;
  logic             out_q;

  logic [CNT_W-1:0] value;
  logic [CNT_W-1:0] cnt_dec;
  logic             commit;
  logic             have;
  logic             trig;
  logic             load;
  logic             dec_en;
  logic             expire;

  strobe_count_stage #(.CNT_W(CNT_W)) i_stage (
    .clk     (clk),
    .rst     (rst),
    .clr     (ctrl_we),
    .we      (cnt_we),
    .byte_in (cnt_byte),
    .value   (value),
    .commit  (commit),
    .have    (have)
  );

  strobe_gate_edge i_edge (
    .clk  (clk),
    .rst  (rst),
    .clr  (ctrl_we),
    .arm  (mode_q == TRIG_HARD),
    .gate (gate),
    .trig (trig)
  );

  strobe_dec_unit #(.DIGITS(DIGITS)) i_dec (
    .cur (cnt_q),
    .bcd (bcd_q),
    .nxt (cnt_dec)
  );

  // software start loads on a completed write, gate start on a captured edge
  assign load   = (mode_q == TRIG_SOFT) ? commit : (trig & have);
  assign dec_en = running_q & ~load & ((mode_q == TRIG_HARD) | gate);
  assign expire = armed_q & dec_en & (cnt_q == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= TRIG_SOFT;
      bcd_q     <= 1'b0;
      cnt_q     <= '0;
      running_q <= 1'b0;
      armed_q   <= 1'b0;
      out_q     <= 1'b1;
    end else if (ctrl_we) begin
      mode_q    <= trig_mode_e'(ctrl_mode);
      bcd_q     <= ctrl_bcd;
      running_q <= 1'b0;
      armed_q   <= 1'b0;
      out_q     <= 1'b1;
    end else begin
      if (load) begin
        cnt_q     <= value;
        running_q <= 1'b1;
        armed_q   <= 1'b1;
      end else begin
        if (dec_en) cnt_q <= cnt_dec;
        if (expire) armed_q <= 1'b0;
      end
      out_q <= ~expire;
    end
  end

  assign strobe_n = out_q;

  logic bcd_ok;
  always_comb begin
    bcd_ok = 1'b1;
    for (int i = 0; i < int'(DIGITS); i++) begin
      if (cnt_q[i*NIBBLE_W +: NIBBLE_W] > 4'd9) bcd_ok = 1'b0;
    end
  end

  // R2: a control write leaves the output high on the next cycle
  p_ctrl_high_r2: assert property (@(posedge clk) disable iff (rst)
    ctrl_we |=> strobe_n);

  // R3: a strobe is one cycle wide
  p_strobe_width_r3: assert property (@(posedge clk) disable iff (rst)
    !strobe_n |=> strobe_n);

  // R5: gate low in software-start mode freezes the count
  p_soft_pause_r5: assert property (@(posedge clk) disable iff (rst)
    (mode_q == TRIG_SOFT && !gate && !commit && !ctrl_we) |=> $stable(cnt_q));

  // R12: BCD digits stay in 0..9 while counting
  p_bcd_digits_r12: assert property (@(posedge clk) disable iff (rst)
    (bcd_q && running_q) |-> bcd_ok);

  // R11: without a fresh load no second strobe follows an expiry
  p_single_strobe_r11: assert property (@(posedge clk) disable iff (rst)
    (!strobe_n && !load) |=> !armed_q);
endmodule

// File: tb/test_strobe_counter.sv
`timescale 1ns/1ps
module test_strobe_counter;
  logic       clk = 1'b0;
  logic       rst;
  logic       ctrl_we, ctrl_mode, ctrl_bcd;
  logic       cnt_we;
  logic [7:0] cnt_byte;
  logic       gate;
  logic       strobe_n;

  int    cyc = 0;
  int    tests = 0;
  int    fails = 0;
  bit    done = 1'b0;
  string cur_req = "R1";
  int    exp_q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  strobe_counter i_strobe_counter (
    .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_mode(ctrl_mode),
    .ctrl_bcd(ctrl_bcd), .cnt_we(cnt_we), .cnt_byte(cnt_byte),
    .gate(gate), .strobe_n(strobe_n)
  );

  // monitor: compare observed strobes with the scoreboard
  always @(negedge clk) begin
    int e;
    if (!rst && !done) begin
      if (exp_q.size() > 0 && exp_q[0] < cyc) begin
        tests++; fails++;
        $display("FAIL %s: strobe actual none, expected at cycle %0d", cur_req, exp_q[0]);
        void'(exp_q.pop_front());
      end
      if (strobe_n === 1'b0) begin
        tests++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL %s (R3/R11 single strobe): strobe actual at cycle %0d, expected none",
                   cur_req, cyc);
        end else begin
          e = exp_q.pop_front();
          if (e != cyc) begin
            fails++;
            $display("FAIL %s: strobe actual at cycle %0d, expected %0d", cur_req, cyc, e);
          end
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_bit(input string req, input logic act, input logic expv);
    tests++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %b, expected %b", req, act, expv);
    end
  endtask

  task automatic ctrl(input bit m, input bit b, input bit with_byte);
    ctrl_we = 1'b1; ctrl_mode = m; ctrl_bcd = b;
    if (with_byte) begin cnt_we = 1'b1; cnt_byte = 8'hAA; end
    @(negedge clk);
    ctrl_we = 1'b0; cnt_we = 1'b0;
  endtask

  // n is the effective count; expect_it replaces pending expectations
  task automatic put_count(input logic [15:0] v, input int n, input bit expect_it, output int c);
    cnt_we = 1'b1; cnt_byte = v[7:0];
    @(negedge clk);
    cnt_byte = v[15:8];
    c = cyc;
    if (expect_it) begin exp_q.delete(); exp_q.push_back(c + n + 2); end
    @(negedge clk);
    cnt_we = 1'b0;
  endtask

  task automatic pulse(input int n, input bit expect_it, output int c);
    gate = 1'b1;
    c = cyc;
    if (expect_it) begin exp_q.delete(); exp_q.push_back(c + n + 2); end
    @(negedge clk);
    gate = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: run actual hung, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int c;
    rst = 1'b1; gate = 1'b1; ctrl_we = 1'b0; ctrl_mode = 1'b0; ctrl_bcd = 1'b0;
    cnt_we = 1'b0; cnt_byte = 8'h00;
    tick(3);
    rst = 1'b0;
    check_bit("R1", strobe_n, 1'b1);
    tick(20);
    check_bit("R1", strobe_n, 1'b1);

    // software start, binary
    cur_req = "R4"; ctrl(1'b0, 1'b0, 1'b0);
    put_count(16'd5, 5, 1'b1, c); tick(15);
    put_count(16'd1, 1, 1'b1, c); tick(10);

    // gate pause
    cur_req = "R5";
    put_count(16'd10, 10, 1'b0, c);
    exp_q.push_back(c + 16);
    tick(2); gate = 1'b0; tick(4); gate = 1'b1; tick(20);

    // mid-sequence reload, low byte alone quiet
    cur_req = "R6";
    put_count(16'd20, 20, 1'b1, c); tick(5);
    put_count(16'd6, 6, 1'b1, c); tick(40);

    // control write abandons sequence; simultaneous byte discarded
    cur_req = "R2";
    put_count(16'd30, 30, 1'b1, c); tick(10);
    exp_q.delete(); ctrl(1'b0, 1'b0, 1'b1);
    check_bit("R2", strobe_n, 1'b1);
    tick(50);
    check_bit("R2", strobe_n, 1'b1);
    put_count(16'd3, 3, 1'b1, c); tick(10);

    // gate-start mode
    cur_req = "R7"; gate = 1'b0;
    ctrl(1'b1, 1'b0, 1'b0);
    pulse(8, 1'b0, c); tick(20);
    put_count(16'd8, 8, 1'b0, c); tick(20);
    check_bit("R7", strobe_n, 1'b1);
    pulse(8, 1'b1, c); tick(20);

    cur_req = "R8";
    put_count(16'd12, 12, 1'b0, c);
    pulse(12, 1'b1, c); tick(5);
    pulse(12, 1'b1, c); tick(30);

    cur_req = "R9";
    put_count(16'd12, 12, 1'b0, c);
    pulse(12, 1'b1, c); tick(2);
    put_count(16'd4, 4, 1'b0, c); tick(20);
    pulse(4, 1'b1, c); tick(15);

    // BCD
    cur_req = "R12"; gate = 1'b1;
    ctrl(1'b0, 1'b1, 1'b0);
    put_count(16'h0015, 15, 1'b1, c); tick(25);
    put_count(16'h0100, 100, 1'b1, c); tick(110);

    cur_req = "R10";
    put_count(16'h0000, 10000, 1'b1, c); tick(10010);
    cur_req = "R11";
    tick(10100);

    cur_req = "R10";
    ctrl(1'b0, 1'b0, 1'b0);
    put_count(16'h0000, 65536, 1'b1, c); tick(65545);

    tests++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R4: pending strobes actual %0d, expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule